// File: doc/BRIEF.md
# CAN Node Status Register

This block implements the upper byte of a CAN controller's control and status word, plus the one control bit in the lower byte that it needs. It tells software whether this node is sending a data or remote frame, whether any such frame is on the bus, and which of four error-confinement levels the node is in. It also keeps a sticky transition flag that can raise an interrupt when that level changes.

The protocol engine supplies frame activity indications and the current confinement code. Each clock, the block registers the code and compares it with the previous value. The flag sets when the node moves one step towards bus-off, or when it recovers from bus-off straight to error active. Software clears the flag by writing 0 to it. Reads that belong to a read-modify-write access show the flag as 1, so a rewrite of the register cannot clear an event by accident. Read data is combinational from the register state and the read qualifier.

Top module: `can_node_status`

## Requirements
- R1: After reset the read word is 0x0000 (with the read-modify-write qualifier low) and `irq` is 0.
- R2: Bit 15 (transmit status) is 1 in the cycle after an edge at which `msg_active` and `own_tx` were 1 and `errovl_active` and `halted` were 0. Otherwise it is 0, including while an error or overload frame is being sent.
- R3: Bit 14 (receive status) is 1 in the cycle after an edge at which `msg_active` was 1 and `errovl_active` and `halted` were 0, whatever the value of `own_tx`. Otherwise it is 0.
- R4: Bits 9:8 show the confinement code sampled at the previous edge, coded 00 error active, 01 warning, 10 error passive, 11 bus off.
- R5: Bit 10 (transition flag) sets at the edge where the registered code changes 00→01, 01→10, 10→11 or 11→00.
- R6: No other code change sets the flag (for example 10→01, 01→00, 00→10, 00→11, 11→10, 10→00).
- R7: A write with `wr_be[1]`=1 and `wr_data[10]`=0 clears the flag. A write with `wr_data[10]`=1, or a write without `wr_be[1]`, leaves the flag unchanged.
- R8: While `rd_rmw` is 1, bit 10 of `rd_data` reads 1. While `rd_rmw` is 0, it reads the true flag value.
- R9: `irq` is 1 exactly when the flag is 1 and the interrupt enable bit is 1.
- R10: The interrupt enable is bit 0 of the lower byte. It is written only by writes with `wr_be[0]`=1, reads back, and resets to 0.
- R11: Bits 13:11 and lower-byte bits 7:1 always read 0.
- R12: If a qualifying transition and a clearing write happen at the same edge, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_active | input | 1 | A data or remote frame is on the bus |
| own_tx | input | 1 | This node is the transmitter of the current frame |
| errovl_active | input | 1 | An error or overload frame is on the bus |
| halted | input | 1 | Controller is stopped from bus operation |
| node_state_i | input | 2 | Current error-confinement code |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables: bit 1 upper byte, bit 0 lower byte |
| wr_data | input | 16 | Write data |
| rd_rmw | input | 1 | Current read belongs to a read-modify-write access |
| rd_data | output | 16 | Register read data |
| irq | output | 1 | Node transition interrupt request |

## Verification
The bench walks the confinement code through all four listed transitions and through six that must not set the flag. A detector that matches any change, or only worsening changes, would miss the bus-off recovery or set the flag on an improvement. It checks that a clear coinciding with a new transition keeps the flag set; a clear-priority design would lose that event. It also checks that writes of 1, or writes without the upper strobe, leave the flag alone, and that a read-modify-write read shows 1 even with the flag clear. For activity, it drives error frames during this node's own transmission and frames during halt. A design that forgot the error/overload or halt qualifiers would keep bits 15 or 14 set.

// File: rtl/can_nsr_pkg.sv
package can_nsr_pkg;
   localparam int NS_W = 2;

   typedef enum logic [NS_W-1:0] {
      NS_ACTIVE  = 2'b00,
      NS_WARN    = 2'b01,
      NS_PASSIVE = 2'b10,
      NS_BUSOFF  = 2'b11
   } node_state_e;

   // register bit positions that software decodes
   localparam int POS_TX   = 15;
   localparam int POS_RX   = 14;
   localparam int POS_FLAG = 10;
   localparam int POS_NS   = 8;

   // a step toward bus-off, or recovery from bus-off to error active
   function automatic logic ns_step_counts(input logic [NS_W-1:0] from_s,
                                           input logic [NS_W-1:0] to_s);
      return ((from_s == NS_ACTIVE)  && (to_s == NS_WARN))    ||
             ((from_s == NS_WARN)    && (to_s == NS_PASSIVE)) ||
             ((from_s == NS_PASSIVE) && (to_s == NS_BUSOFF))  ||
             ((from_s == NS_BUSOFF)  && (to_s == NS_ACTIVE));
   endfunction
endpackage

// File: rtl/can_nsr_activity.sv
module can_nsr_activity #(
   parameter bit REG_ACTIVITY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic msg_active,
   input  logic own_tx,
   input  logic errovl_active,
   input  logic halted,
   output logic tx_stat,
   output logic rx_stat
);
   logic bus_msg;
   logic tx_raw;

   always_comb begin
      bus_msg = msg_active & ~errovl_active & ~halted;
      tx_raw  = bus_msg & own_tx;
   end

   generate
      if (REG_ACTIVITY) begin : g_reg
         logic tx_q;
         logic rx_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tx_q <= 1'b0;
               rx_q <= 1'b0;
            end else begin
               tx_q <= tx_raw;
               rx_q <= bus_msg;
            end
         end
         assign tx_stat = tx_q;
         assign rx_stat = rx_q;
      end else begin : g_comb
         assign tx_stat = tx_raw;
         assign rx_stat = bus_msg;
      end
   endgenerate
endmodule

// File: rtl/can_nsr_trans.sv
module can_nsr_trans
   import can_nsr_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NS_W-1:0] node_state_i,
   input  logic            flag_clr,
   output logic [NS_W-1:0] ns_q,
   output logic            trans_flag
);
   logic step_hit;
   logic flag_d;

   always_comb begin
      step_hit = ns_step_counts(ns_q, node_state_i);
      // a new event beats a clear at the same edge
      flag_d   = step_hit | (trans_flag & ~flag_clr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ns_q       <= NS_ACTIVE;
         trans_flag <= 1'b0;
      end else begin
         ns_q       <= node_state_i;
         trans_flag <= flag_d;
      end
   end
endmodule

// File: rtl/can_nsr_regif.sv
module can_nsr_regif
   import can_nsr_pkg::*;
#(
   parameter int REG_W  = 16,
   parameter int IE_BIT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W/8-1:0] wr_be,
   input  logic [REG_W-1:0] wr_data,
   input  logic             rd_rmw,
   input  logic             tx_stat,
   input  logic             rx_stat,
   input  logic [NS_W-1:0]  ns_q,
   input  logic             trans_flag,
   output logic             flag_clr,
   output logic             ie_q,
   output logic [REG_W-1:0] rd_data
);
   localparam int BYTE_W = 8;
   localparam int HI_BE  = 1;
   localparam int LO_BE  = 0;

   always_comb flag_clr = wr_en & wr_be[HI_BE] & ~wr_data[POS_FLAG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ie_q <= 1'b0;
      else if (wr_en && wr_be[LO_BE])  ie_q <= wr_data[IE_BIT];
   end

   always_comb begin
      rd_data                   = '0;
      rd_data[POS_TX]           = tx_stat;
      rd_data[POS_RX]           = rx_stat;
      rd_data[POS_FLAG]         = trans_flag | rd_rmw;
      rd_data[POS_NS +: NS_W]   = ns_q;
      rd_data[IE_BIT]           = ie_q;
   end

   generate
      if (IE_BIT < 0 || IE_BIT >= BYTE_W) begin : g_bad_ie
         $error("IE_BIT must lie in the lower byte");
      end
   endgenerate
endmodule

// File: rtl/can_node_status.sv
module can_node_status
   import can_nsr_pkg::*;
#(
   parameter int REG_W        = 16,
   parameter int IE_BIT       = 0,
   parameter bit REG_ACTIVITY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             msg_active,
   input  logic             own_tx,
   input  logic             errovl_active,
   input  logic             halted,
   input  logic [1:0]       node_state_i,
   input  logic             wr_en,
   input  logic [1:0]       wr_be,
   input  logic [15:0]      wr_data,
   input  logic             rd_rmw,
   output logic [15:0]      rd_data,
   output logic             irq
);
   generate
      if (REG_W != 16) begin : g_bad_w
         $error("REG_W must be 16");
      end
   endgenerate

   logic            tx_stat;
   logic            rx_stat;
   logic [NS_W-1:0] ns_q;
   logic            trans_flag;
   logic            flag_clr;
   logic            ie_q;

   can_nsr_activity #(.REG_ACTIVITY(REG_ACTIVITY)) u_act (
      .clk(clk), .rst_n(rst_n), .msg_active(msg_active), .own_tx(own_tx),
      .errovl_active(errovl_active), .halted(halted),
      .tx_stat(tx_stat), .rx_stat(rx_stat)
   );

   can_nsr_trans u_trans (
      .clk(clk), .rst_n(rst_n), .node_state_i(node_state_i),
      .flag_clr(flag_clr), .ns_q(ns_q), .trans_flag(trans_flag)
   );

   can_nsr_regif #(.REG_W(REG_W), .IE_BIT(IE_BIT)) u_regif (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
      .wr_data(wr_data), .rd_rmw(rd_rmw), .tx_stat(tx_stat),
      .rx_stat(rx_stat), .ns_q(ns_q), .trans_flag(trans_flag),
      .flag_clr(flag_clr), .ie_q(ie_q), .rd_data(rd_data)
   );

   always_comb irq = trans_flag & ie_q;
endmodule

// File: rtl/can_node_status_chk.sv
module can_node_status_chk
   import can_nsr_pkg::*;
#(
   parameter int IE_BIT       = 0,
   parameter bit REG_ACTIVITY = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        msg_active,
   input logic        errovl_active,
   input logic        halted,
   input logic [1:0]  node_state_i,
   input logic [1:0]  ns_q,
   input logic        trans_flag,
   input logic        wr_en,
   input logic [1:0]  wr_be,
   input logic [15:0] wr_data,
   input logic        rd_rmw,
   input logic [15:0] rd_data,
   input logic        irq
);
   logic clr_req;
   logic hit;
   always_comb begin
      clr_req = wr_en & wr_be[1] & ~wr_data[POS_FLAG];
      hit     = ns_step_counts(ns_q, node_state_i);
   end

   AST_SET_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> trans_flag); // R5
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && clr_req) |=> trans_flag); // R12
   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !hit) |=> !trans_flag); // R7
   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (trans_flag && !clr_req) |=> trans_flag); // R7
   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!trans_flag && !hit) |=> !trans_flag); // R6
   AST_NS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rd_data[9:8] == $past(node_state_i))); // R4
   AST_RMW_SHOWS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rmw |-> rd_data[POS_FLAG]); // R8
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[13:11] == 3'b000)); // R11
   AST_TX_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[POS_TX] |-> rd_data[POS_RX]); // R2
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (trans_flag && (rd_rmw || rd_data[IE_BIT]))); // R9

   generate
      if (REG_ACTIVITY) begin : g_reg_chk
         AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (halted || errovl_active || !msg_active) |=> !rd_data[POS_RX]); // R3
      end else begin : g_comb_chk
         AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (halted || errovl_active || !msg_active) |-> !rd_data[POS_RX]); // R3
      end
   endgenerate
endmodule

bind can_node_status can_node_status_chk #(
   .IE_BIT(IE_BIT), .REG_ACTIVITY(REG_ACTIVITY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .msg_active(msg_active),
   .errovl_active(errovl_active), .halted(halted),
   .node_state_i(node_state_i), .ns_q(ns_q), .trans_flag(trans_flag),
   .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .rd_rmw(rd_rmw),
   .rd_data(rd_data), .irq(irq)
);

// File: tb/tb_can_node_status.sv
module tb_can_node_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msg_active = 1'b0, own_tx = 1'b0, errovl_active = 1'b0, halted = 1'b0;
   logic [1:0]  node_state_i = 2'b00;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_be = 2'b00;
   logic [15:0] wr_data = 16'h0000;
   logic        rd_rmw = 1'b0;
   logic [15:0] rd_data;
   logic        irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   can_node_status dut (
      .clk(clk), .rst_n(rst_n), .msg_active(msg_active), .own_tx(own_tx),
      .errovl_active(errovl_active), .halted(halted),
      .node_state_i(node_state_i), .wr_en(wr_en), .wr_be(wr_be),
      .wr_data(wr_data), .rd_rmw(rd_rmw), .rd_data(rd_data), .irq(irq)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock; inputs change and outputs are sampled 5 ns after the edge
   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic rd(input logic rmw, output logic [15:0] v);
      rd_rmw = rmw;
      #1;
      v = rd_data;
      rd_rmw = 1'b0;
      #1;
   endtask

   task automatic wr(input logic [1:0] be, input logic [15:0] d);
      wr_en = 1'b1; wr_be = be; wr_data = d;
      tick();
      wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0000;
   endtask

   task automatic go_state(input logic [1:0] s);
      node_state_i = s;
      tick();
   endtask

   function automatic logic [15:0] word(input logic [1:0] ns, input logic f, input logic ie);
      return {5'b00000, f, ns, 7'b0000000, ie};
   endfunction

   task automatic t_reset();
      logic [15:0] v;
      rd(1'b0, v);
      check("R1 reset word", v, 16'h0000);
      check("R1 reset irq", {15'd0, irq}, 16'h0000);
   endtask

   task automatic t_activity();
      logic [15:0] v;
      msg_active = 1'b1; own_tx = 1'b1; tick(); rd(1'b0, v);
      check("R2 own tx", v & 16'hC000, 16'hC000);
      own_tx = 1'b0; tick(); rd(1'b0, v);
      check("R3 rx of other node", v & 16'hC000, 16'h4000);
      own_tx = 1'b1; errovl_active = 1'b1; tick(); rd(1'b0, v);
      check("R2 error frame while tx", v & 16'hC000, 16'h0000);
      errovl_active = 1'b0; halted = 1'b1; tick(); rd(1'b0, v);
      check("R3 halted", v & 16'hC000, 16'h0000);
      halted = 1'b0; msg_active = 1'b0; tick(); rd(1'b0, v);
      check("R3 bus idle", v & 16'hC000, 16'h0000);
      own_tx = 1'b0;
   endtask

   task automatic t_steps();
      logic [15:0] v;
      logic [1:0] seq [4] = '{2'b01, 2'b10, 2'b11, 2'b00};
      for (int i = 0; i < 4; i++) begin
         go_state(seq[i]); rd(1'b0, v);
         check("R5 R4 worsening or recovery sets flag", v, word(seq[i], 1'b1, 1'b0));
         wr(2'b10, 16'h0000); rd(1'b0, v);
         check("R7 clear by writing 0", v, word(seq[i], 1'b0, 1'b0));
      end
   endtask

   task automatic t_no_set();
      logic [15:0] v;
      logic [1:0] seq [7] = '{2'b10, 2'b01, 2'b00, 2'b11, 2'b10, 2'b00, 2'b00};
      // 00->10, 10->01, 01->00, 00->11, 11->10, 10->00, hold 00
      for (int i = 0; i < 7; i++) begin
         go_state(seq[i]); rd(1'b0, v);
         check("R6 non-qualifying change", v, word(seq[i], 1'b0, 1'b0));
      end
   endtask

   task automatic t_write_one_and_strobe();
      logic [15:0] v;
      go_state(2'b01);
      wr(2'b10, 16'h0400); rd(1'b0, v);
      check("R7 write 1 ignored", v, word(2'b01, 1'b1, 1'b0));
      wr(2'b01, 16'h0000); rd(1'b0, v);
      check("R7 no upper strobe ignored", v, word(2'b01, 1'b1, 1'b0));
      wr(2'b10, 16'h0000); rd(1'b0, v);
      check("R7 clear", v, word(2'b01, 1'b0, 1'b0));
   endtask

   task automatic t_rmw();
      logic [15:0] v;
      rd(1'b1, v);
      check("R8 rmw read shows 1", v, word(2'b01, 1'b1, 1'b0));
      rd(1'b0, v);
      check("R8 plain read true value", v, word(2'b01, 1'b0, 1'b0));
   endtask

   task automatic t_ie_irq();
      logic [15:0] v;
      wr(2'b10, 16'h00FF); rd(1'b0, v);
      check("R10 ie needs lower strobe", v, word(2'b01, 1'b0, 1'b0));
      wr(2'b01, 16'hFFFF); rd(1'b0, v);
      check("R10 R11 ie set, other lower bits 0", v, word(2'b01, 1'b0, 1'b1));
      check("R9 no irq without flag", {15'd0, irq}, 16'h0000);
      go_state(2'b10);
      check("R9 irq with flag and ie", {15'd0, irq}, 16'h0001);
      wr(2'b01, 16'h0000);
      check("R9 irq drops with ie", {15'd0, irq}, 16'h0000);
      rd(1'b0, v);
      check("R10 ie cleared, flag kept", v, word(2'b10, 1'b1, 1'b0));
      wr(2'b10, 16'h0000);
   endtask

   task automatic t_race();
      logic [15:0] v;
      node_state_i = 2'b11;
      wr(2'b10, 16'h0000); rd(1'b0, v);
      check("R12 set wins over clear", v, word(2'b11, 1'b1, 1'b0));
      wr(2'b10, 16'h0000); rd(1'b0, v);
      check("R12 later clear works", v, word(2'b11, 1'b0, 1'b0));
      check("R11 reserved bits", v & 16'h38FE, 16'h0000);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #35;
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_activity();
      t_steps();
      t_no_set();
      t_write_one_and_strobe();
      t_rmw();
      t_ie_irq();
      t_race();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule